// File: doc/BRIEF.md
# M68K-Family 16-Bit Asynchronous Bus Slave

This block sits between a 32-bit M68K-family host that uses dynamic bus sizing and an internal 16-bit register or memory space. The host starts an access by lowering its address and data strobes while chip select is low. The slave answers as a 16-bit port. It carries data on the upper half of the host data bus, D[31:16], and it signals completion on a single port-size acknowledge line. Toward the inside it raises a one-cycle request with a word address, a write flag, byte enables and write data, and it waits for a ready pulse.

Both strobes pass through a two-flop synchronizer on the bus clock. A state machine then moves through these states: `ST_IDLE` (everything floating), `ST_ARM` (acknowledge driven high while waiting for the data strobe), `ST_ISSUE` (request pulse), `ST_MEMWAIT` (waiting for ready), `ST_HOLDOFF` (the configured wait states), `ST_ACK` (acknowledge driven low) and `ST_RELEASE` (acknowledge driven high for one clock before it floats). The transitions are:
- IDLE→ARM when the strobe is low with chip select low.
- ARM→ISSUE when the data strobe is low.
- ARM→RELEASE when the strobe is withdrawn early.
- ISSUE→MEMWAIT unconditionally.
- MEMWAIT→HOLDOFF on ready.
- HOLDOFF→ACK when the wait count expires.
- ACK→RELEASE when the strobe rises.
- RELEASE→IDLE unconditionally.

The bus clock may be stopped low between or during accesses. No state changes without a clock edge.

Top module: `hbs_slave16`

## Requirements
- R1: The data path is 16 bits wide and maps to the host's upper lanes. `wr_data[15:8]`/`rd_data[15:8]` carry D[31:24] and `wr_data[7:0]`/`rd_data[7:0]` carry D[23:16]. A word read returns the internal word unchanged on `rd_data`.
- R2: Address, size, direction and chip select are captured when the synchronized address strobe is first seen low. `mem_addr` equals `addr[ADDR_W-1:1]` of that access.
- R3: With chip select low, `ack_oe` rises after the third rising clock edge following the address strobe falling, and `ack_n` is then high.
- R4: `ack_n` goes low after exactly `WAIT_STATES` (at least 1) rising edges following the edge that sees `mem_rdy`. It stays low until the synchronized strobe rise is seen.
- R5: After the strobe rises, `ack_n` is driven high (with `ack_oe` high) for exactly one clock, and then `ack_oe` falls.
- R6: On a read, `rd_oe` is high from the cycle after `mem_rdy` is seen until the release cycle, carrying the ready data. So the data is valid before `ack_n` falls, and it is released together with the high-drive cycle of the acknowledge.
- R7: Write data is sampled only on the edge that sees the synchronized data strobe low. This is two or more edges after the data strobe falls, so a late data strobe delays the request by the same number of cycles.
- R8: With the clock held low for any time, all outputs and state hold. The access completes with the same count of rising edges as an unpaused one.
- R9: The byte enables use `siz` codes 01 = byte, 10 = word, 11 = three bytes, 00 = long. A byte at an even address gives `mem_be` = 10 (upper lane). A byte at an odd address gives 01. Any other size gives 11.
- R10: `mem_req` is high for exactly one cycle per access, the fourth clock after the strobe falls when the data strobe falls with it. `mem_we` is the inverse of `rw` (1 = read). `mem_wdata` is the sampled write data.
- R11: With chip select high, `ack_oe`, `rd_oe` and `mem_req` stay low for the whole strobe.
- R12: After reset, `ack_oe`, `rd_oe` and `mem_req` are low and `ack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, may be held low |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rw | input | 1 | 1 = read, 0 = write |
| siz | input | 2 | Transfer size code |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 16 | Host data lanes D[31:16] inbound |
| rd_data | output | 16 | Read data for lanes D[31:16] |
| rd_oe | output | 1 | Drive enable for D[31:16] |
| ack_n | output | 1 | Port-size acknowledge level |
| ack_oe | output | 1 | Drive enable for the acknowledge |
| mem_req | output | 1 | One-cycle internal request |
| mem_addr | output | ADDR_W-1 | Internal word address |
| mem_we | output | 1 | Internal write flag |
| mem_be | output | 2 | Byte enables, bit 1 = upper lane |
| mem_wdata | output | 16 | Internal write data |
| mem_rdy | input | 1 | Internal ready pulse |
| mem_rdata | input | 16 | Internal read data, valid with ready |

## Verification
The hardest situation to reach from the ports is one where the access is stretched in several ways at once. This means a data strobe that falls cycles after the address strobe, a slow ready, and a bus clock that stops in the middle of the access. Each changes the cycle of the acknowledge differently.

The bench drives accesses from a behavioural host and memory. It offsets the data strobe by a chosen number of cycles and returns ready after a chosen latency. In one access it holds the clock low in the middle. A reference built from edge counts predicts every output on every clock.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARM     = 3'd1,
        ST_ISSUE   = 3'd2,
        ST_MEMWAIT = 3'd3,
        ST_HOLDOFF = 3'd4,
        ST_ACK     = 3'd5,
        ST_RELEASE = 3'd6
    } hbs_state_e;

    localparam logic [1:0] SIZ_LONG  = 2'b00;
    localparam logic [1:0] SIZ_BYTE  = 2'b01;
    localparam logic [1:0] SIZ_WORD  = 2'b10;
    localparam logic [1:0] SIZ_TRIPLE = 2'b11;

    localparam int LANE_W = 16;

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '1;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbs_lanes.sv
module hbs_lanes
    import hbs_pkg::*;
(
    input  logic [1:0] siz,
    input  logic       a0,
    output logic [1:0] be
);
    always_comb begin
        unique case (siz)
            SIZ_BYTE:   be = a0 ? 2'b01 : 2'b10;
            SIZ_WORD,
            SIZ_TRIPLE,
            SIZ_LONG:   be = 2'b11;
            default:    be = 2'b11;
        endcase
    end
endmodule

// File: rtl/hbs_holdoff.sv
module hbs_holdoff #(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int WEFF  = (WAIT_STATES < 1) ? 1 : WAIT_STATES;
    localparam int CNT_W = $clog2(WEFF + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WEFF - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= RELOAD;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R4
    holdoff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= RELOAD);

    // R4
    holdoff_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/hbs_slave16.sv
module hbs_slave16
    import hbs_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int WAIT_STATES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [1:0]        siz,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              rd_oe,
    output logic              ack_n,
    output logic              ack_oe,
    output logic              mem_req,
    output logic [ADDR_W-2:0] mem_addr,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic              mem_rdy,
    input  logic [15:0]       mem_rdata
);
    localparam int WORD_AW = ADDR_W - 1;

    hbs_state_e state_q, state_d;

    logic              as_s, ds_s;
    logic [1:0]        strobe_s;
    logic [1:0]        be_dec;
    logic [WORD_AW-1:0] addr_q;
    logic              rw_q;
    logic [1:0]        be_q;
    logic [15:0]       wdata_q;
    logic [15:0]       rdata_q;
    logic              hold_load, hold_run, hold_done;
    logic              take_addr, take_wdata, take_rdata;

    hbs_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({as_n, ds_n}),
        .q     (strobe_s)
    );
    assign as_s = strobe_s[1];
    assign ds_s = strobe_s[0];

    hbs_lanes u_lanes (
        .siz (siz),
        .a0  (addr[0]),
        .be  (be_dec)
    );

    hbs_holdoff #(.WAIT_STATES(WAIT_STATES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hold_load),
        .run   (hold_run),
        .done  (hold_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (!as_s && !cs_n) state_d = ST_ARM;
            ST_ARM: begin
                if (as_s)       state_d = ST_RELEASE;
                else if (!ds_s) state_d = ST_ISSUE;
            end
            ST_ISSUE:   state_d = ST_MEMWAIT;
            ST_MEMWAIT: if (mem_rdy) state_d = ST_HOLDOFF;
            ST_HOLDOFF: if (hold_done) state_d = ST_ACK;
            ST_ACK:     if (as_s) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign take_addr  = (state_q == ST_IDLE) && !as_s && !cs_n;
    assign take_wdata = (state_q == ST_ARM) && !as_s && !ds_s;
    assign take_rdata = (state_q == ST_MEMWAIT) && mem_rdy;
    assign hold_load  = take_rdata;
    assign hold_run   = (state_q == ST_HOLDOFF);

    // access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rw_q    <= 1'b1;
            be_q    <= 2'b00;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (take_addr) begin
                addr_q <= addr[ADDR_W-1:1];
                rw_q   <= rw;
                be_q   <= be_dec;
            end
            if (take_wdata) wdata_q <= wr_data;
            if (take_rdata) rdata_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        ack_oe    = 1'b0;
        ack_n     = 1'b1;
        rd_oe     = 1'b0;
        mem_req   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_ARM,
            ST_MEMWAIT,
            ST_RELEASE: ack_oe = 1'b1;
            ST_ISSUE: begin
                ack_oe  = 1'b1;
                mem_req = 1'b1;
            end
            ST_HOLDOFF: begin
                ack_oe = 1'b1;
                rd_oe  = rw_q;
            end
            ST_ACK: begin
                ack_oe = 1'b1;
                ack_n  = 1'b0;
                rd_oe  = rw_q;
            end
            default: ;
        endcase
        rd_data   = rdata_q;
        mem_addr  = addr_q;
        mem_we    = ~rw_q;
        mem_be    = be_q;
        mem_wdata = wdata_q;
    end

    // R5
    release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_oe) |-> $past(ack_n));

    // R3
    ack_driven_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(ack_oe));

    // R10
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R9
    be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be != 2'b00));

    // R6
    rd_oe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> ack_oe);

    // R11
    cs_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cs_n) |=> !ack_oe);

    // R4
    ack_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEMWAIT && mem_rdy) |=> ack_n);
endmodule

// File: tb/tb_hbs_slave16.sv
module tb_hbs_slave16;
    localparam int AW = 16;
    localparam int W  = 2;

    logic clk = 1'b0, clk_en = 1'b1, rst_n = 1'b0;
    logic cs_n = 1'b1, as_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
    logic [1:0] siz = 2'b10;
    logic [AW-1:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic rd_oe, ack_n, ack_oe, mem_req, mem_we;
    logic [AW-2:0] mem_addr;
    logic [1:0] mem_be;
    logic [15:0] mem_wdata;
    logic mem_rdy = 1'b0;
    logic [15:0] mem_rdata = '0;

    int vectors = 0, miscompares = 0;
    bit finished = 0;
    logic [15:0] mem [0:255];

    hbs_slave16 #(.ADDR_W(AW), .WAIT_STATES(W)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .ds_n(ds_n),
        .rw(rw), .siz(siz), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_oe(rd_oe), .ack_n(ack_n), .ack_oe(ack_oe),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
        .mem_rdata(mem_rdata)
    );

    always #2 clk = clk_en ? ~clk : 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_be(input logic [1:0] sz, input logic a0);
        if (sz == 2'b01) return a0 ? 2'b01 : 2'b10;
        return 2'b11;
    endfunction

    // One host access with a behavioural memory and an edge-count reference.
    task automatic access(input bit rd, input logic [15:0] a, input logic [1:0] sz,
                          input logic [15:0] wd, input int dsdel, input int lat,
                          input bit pause, input bit sel, output logic [15:0] rdv);
        int s, eack, mcnt, c;
        logic [7:0] idx;
        logic we_l;
        logic [1:0] be_l;
        logic [15:0] wd_l, exp_rd;
        bit oe_e, ackl_e, req_e, rdoe_e;
        s = (dsdel > 1) ? dsdel - 1 : 0;
        eack = 5 + s + lat + W;
        mcnt = 0; rdv = '0; exp_rd = '0; idx = '0; we_l = 0; be_l = '0; wd_l = '0;
        @(negedge clk);
        cs_n = ~sel; rw = rd; siz = sz; addr = a; as_n = 1'b0;
        ds_n = (dsdel == 0) ? 1'b0 : 1'b1;
        wr_data = (dsdel == 0) ? wd : 16'hDEAD;
        for (c = 1; c <= eack + 6; c++) begin
            @(negedge clk);
            mem_rdy = 1'b0;
            if (mcnt > 0) begin
                mcnt--;
                if (mcnt == 0) begin
                    mem_rdy = 1'b1;
                    mem_rdata = mem[idx];
                    exp_rd = mem[idx];
                    if (we_l) begin
                        if (be_l[1]) mem[idx][15:8] = wd_l[15:8];
                        if (be_l[0]) mem[idx][7:0]  = wd_l[7:0];
                    end
                end
            end
            vectors++;
            if (sel) begin
                oe_e   = (c >= 3) && (c <= eack + 3);
                ackl_e = (c >= eack) && (c <= eack + 2);
                req_e  = (c == 4 + s);
                rdoe_e = rd && (c >= eack - W) && (c <= eack + 2);
            end else begin
                oe_e = 0; ackl_e = 0; req_e = 0; rdoe_e = 0;
            end
            // R3 R5 R8 R11 acknowledge drive window
            chk(ack_oe == oe_e, "R3/R5/R8/R11 ack_oe", ack_oe, oe_e);
            // R4 acknowledge level
            if (oe_e) chk(ack_n == !ackl_e, "R4 ack_n", ack_n, !ackl_e);
            // R10 R7 request pulse
            chk(mem_req == req_e, "R10/R7 mem_req", mem_req, req_e);
            // R6 R11 read drive window
            chk(rd_oe == rdoe_e, "R6/R11 rd_oe", rd_oe, rdoe_e);
            // R1 R6 read data on the upper lanes
            if (rdoe_e) chk(rd_data == exp_rd, "R1/R6 rd_data", rd_data, exp_rd);
            if (req_e) begin
                // R2 word address
                chk(mem_addr == a[AW-1:1], "R2 mem_addr", mem_addr, a[AW-1:1]);
                // R10 direction
                chk(mem_we == !rd, "R10 mem_we", mem_we, !rd);
                // R9 lane enables
                chk(mem_be == exp_be(sz, a[0]), "R9 mem_be", mem_be, exp_be(sz, a[0]));
                // R7 write data sampled after strobe
                if (!rd) chk(mem_wdata == wd, "R7 mem_wdata", mem_wdata, wd);
            end
            if (mem_req) begin
                mcnt = lat; idx = mem_addr[7:0]; we_l = mem_we;
                be_l = mem_be; wd_l = mem_wdata;
            end
            if (c == dsdel) begin
                ds_n = 1'b0; wr_data = wd;
            end
            if (sel && c == eack && !ack_n && ack_oe) begin
                rdv = rd_data; as_n = 1'b1; ds_n = 1'b1;
            end
            if (!sel && c == 12) begin
                as_n = 1'b1; ds_n = 1'b1;
            end
            if (pause && c == 5) begin
                clk_en = 1'b0;
                #100;
                // R8 outputs hold while the clock is stopped
                vectors++;
                chk(ack_oe == 1'b1 && mem_req == 1'b0, "R8 hold ack_oe", ack_oe, 1);
                clk_en = 1'b1;
            end
        end
        as_n = 1'b1; ds_n = 1'b1; cs_n = 1'b1; mem_rdy = 1'b0;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            miscompares++;
            $display("FAIL R12 watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 16'h0100);
        repeat (3) @(negedge clk);
        // R12 reset state
        vectors++;
        chk(!ack_oe && ack_n && !rd_oe && !mem_req, "R12 reset", {ack_oe, ack_n, rd_oe, mem_req}, 4'b0100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R10 word write then read
        access(0, 16'h0010, 2'b10, 16'h1234, 0, 1, 0, 1, r);
        access(1, 16'h0010, 2'b10, 16'h0000, 0, 1, 0, 1, r);
        vectors++; chk(r == 16'h1234, "R1 word readback", r, 16'h1234);
        // R9 byte at odd address on lower lane
        access(0, 16'h0011, 2'b01, 16'h00AB, 0, 2, 0, 1, r);
        access(1, 16'h0010, 2'b00, 16'h0000, 0, 1, 0, 1, r);
        vectors++; chk(r == 16'h12AB, "R9 odd byte merge", r, 16'h12AB);
        // R9 byte at even address on upper lane
        access(0, 16'h0012, 2'b01, 16'hCD00, 0, 1, 0, 1, r);
        access(1, 16'h0012, 2'b11, 16'h0000, 0, 3, 0, 1, r);
        vectors++; chk(r == {8'hCD, mem[9][7:0]}, "R9 even byte merge", r, {8'hCD, mem[9][7:0]});
        // R7 late data strobe
        access(0, 16'h0020, 2'b10, 16'h5A5A, 3, 1, 0, 1, r);
        access(1, 16'h0020, 2'b10, 16'h0000, 2, 4, 0, 1, r);
        vectors++; chk(r == 16'h5A5A, "R7 late strobe data", r, 16'h5A5A);
        // R8 clock stopped mid-access, then between accesses
        access(1, 16'h0040, 2'b10, 16'h0000, 0, 2, 1, 1, r);
        vectors++; chk(r == mem[32], "R8 paused read", r, mem[32]);
        @(negedge clk); clk_en = 1'b0; #200; clk_en = 1'b1;
        vectors++; chk(!ack_oe && !rd_oe, "R8 idle hold", ack_oe, 0);
        // R11 chip select high
        access(0, 16'h0010, 2'b10, 16'hFFFF, 0, 1, 0, 0, r);
        access(1, 16'h0010, 2'b10, 16'h0000, 0, 1, 0, 1, r);
        vectors++; chk(r == 16'h12AB, "R11 deselected write ignored", r, 16'h12AB);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule